// File: doc/BRIEF.md
# Ethernet Pause Frame Detector

This block watches the receive side of an Ethernet MAC, one byte per clock, and decides for every frame whether it is a valid full-duplex flow-control pause request. Frame bytes arrive on a byte bus qualified by a valid strobe. The first byte is marked by a start-of-frame flag. A separate end-of-frame strobe, which carries the good/bad verdict of the receive checks, closes the frame. Preamble is already removed and the frame check sequence is already judged upstream.

A frame is accepted as a pause request when several conditions all hold. The destination is either the reserved flow-control multicast group or the station's own unicast address. The type and opcode fields carry the pause values. The frame is long enough to hold the duration field. Its end status is good. Both the full-duplex and the flow-control enable inputs are high. On acceptance the block emits a single-cycle pulse and publishes the 16-bit pause duration. The duration stays on its output until the next accepted frame. What the transmitter does with the pause is left to other logic.

Top module: `pause_frame_detector`

## Requirements
- R1: A pause is reported only when `fullDuplex` and `flowCtlEn` are both high in the end-of-frame cycle; with either low, no pulse is issued and `pauseQuanta` keeps its value.
- R2: The destination address (frame bytes 0..5, most significant byte first) must equal 01-80-C2-00-00-01 or equal `stationAddr` (bits 47:40 compared with byte 0). Any other destination is rejected.
- R3: The source address (bytes 6..11) has no influence on the decision.
- R4: Bytes 12..13 must equal 0x88, 0x08 and bytes 14..15 must equal 0x00, 0x01 (type, then opcode). A mismatch in any of these bytes rejects the frame.
- R5: On a detection, `pauseQuanta` takes the value {byte 16, byte 17}, which may be any value from 0x0000 to 0xFFFF. It holds that value until the next detection.
- R6: A pause is reported only when `eofGood` is high with `eofIn`.
- R7: A frame with fewer than 18 bytes is never reported. A frame longer than 18 bytes is judged on its first 18 bytes.
- R8: A byte with `sofIn` high is byte 0 of a new frame and discards all partial match state. Bytes that arrive when no frame is open are ignored. A byte presented in the same cycle as `eofIn` is ignored.
- R9: `pauseHit` rises in the cycle after the end-of-frame cycle, stays high for exactly one cycle, and `pauseQuanta` changes only in that cycle.
- R10: After reset, `pauseHit` is 0 and `pauseQuanta` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Received frame byte |
| byteValid | input | 1 | `rxByte` carries a frame byte this cycle |
| sofIn | input | 1 | With `byteValid`: this byte is the first of a frame |
| eofIn | input | 1 | End of the current frame (cycle after the last byte or later) |
| eofGood | input | 1 | Frame status with `eofIn`: 1 = frame is valid |
| stationAddr | input | 48 | Station's own unicast address, first-transmitted byte in bits 47:40 |
| fullDuplex | input | 1 | Link runs in full-duplex mode |
| flowCtlEn | input | 1 | Receive flow control enabled |
| pauseHit | output | 1 | One-cycle pulse: a valid pause frame was received |
| pauseQuanta | output | 16 | Duration of the most recently detected pause |

## Verification
The one result with a timing rule is the verdict. When `eofIn` is driven in a cycle, `pauseHit` and the new `pauseQuanta` appear after exactly one rising edge. Every input therefore changes on a falling edge, and the bench samples the outputs on the falling edge that follows the end-of-frame cycle. One more falling edge later it confirms the pulse has dropped and the duration is unchanged. Each expected verdict comes from a bench function that reads only the bytes the bench sent, the status and the enables, so rejected frames and frames with ignored bytes are checked against the last accepted duration.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;

  parameter int IDX_W = 5;

  localparam logic [IDX_W-1:0] IDX_MAX     = '1;
  localparam logic [IDX_W-1:0] DA_LAST_IDX = IDX_W'(5);
  localparam logic [IDX_W-1:0] TYPE_HI_IDX = IDX_W'(12);
  localparam logic [IDX_W-1:0] TYPE_LO_IDX = IDX_W'(13);
  localparam logic [IDX_W-1:0] OP_HI_IDX   = IDX_W'(14);
  localparam logic [IDX_W-1:0] OP_LO_IDX   = IDX_W'(15);
  localparam logic [IDX_W-1:0] DUR_HI_IDX  = IDX_W'(16);
  localparam logic [IDX_W-1:0] DUR_LO_IDX  = IDX_W'(17);
  localparam logic [IDX_W-1:0] MIN_BYTES   = IDX_W'(18);

  typedef struct packed {
    logic             startFrame;
    logic             takeByte;
    logic [IDX_W-1:0] byteIdx;
    logic             commit;
  } ctlStrobe_t;

  function automatic logic [7:0] addrByte(input logic [47:0] addr,
                                          input logic [IDX_W-1:0] idx);
    logic [7:0] b;
    case (idx)
      IDX_W'(0): b = addr[47:40];
      IDX_W'(1): b = addr[39:32];
      IDX_W'(2): b = addr[31:24];
      IDX_W'(3): b = addr[23:16];
      IDX_W'(4): b = addr[15:8];
      IDX_W'(5): b = addr[7:0];
      default:   b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pause_det_ctl.sv
module pause_det_ctl
  import pause_det_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       sofIn,
  input  logic       eofIn,
  input  logic       eofGood,
  input  logic       fullDuplex,
  input  logic       flowCtlEn,
  input  logic       fieldsOk,
  output ctlStrobe_t strobe,
  output logic       pauseHit
);

  logic             inFrame;
  logic [IDX_W-1:0] byteCnt;
  logic             longEnough;
  logic             enabled;

  assign longEnough = (byteCnt >= MIN_BYTES);
  assign enabled    = fullDuplex && flowCtlEn;

  always_comb begin
    strobe.startFrame = byteValid && sofIn && !eofIn;
    strobe.takeByte   = byteValid && !eofIn && (sofIn || inFrame);
    strobe.byteIdx    = strobe.startFrame ? '0 : byteCnt;
    strobe.commit     = eofIn && inFrame && longEnough && eofGood
                        && enabled && fieldsOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      byteCnt  <= '0;
      pauseHit <= 1'b0;
    end else begin
      pauseHit <= strobe.commit;
      if (eofIn) begin
        inFrame <= 1'b0;
      end else if (strobe.startFrame) begin
        inFrame <= 1'b1;
        byteCnt <= IDX_W'(1);
      end else if (strobe.takeByte && byteCnt != IDX_MAX) begin
        byteCnt <= byteCnt + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/pause_det_dp.sv
module pause_det_dp
  import pause_det_pkg::*;
#(
  parameter logic [47:0] GROUP_ADDR = 48'h0180_C200_0001,
  parameter logic [15:0] PAUSE_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP   = 16'h0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  strobe,
  input  logic [7:0]  rxByte,
  input  logic [47:0] stationAddr,
  output logic        fieldsOk,
  output logic [15:0] pauseQuanta
);

  logic        grpOk, uniOk, typeOk, opOk;
  logic        grpBase, uniBase, typeBase, opBase;
  logic        grpNext, uniNext, typeNext, opNext;
  logic [15:0] durShadow;
  logic [15:0] quantaReg;
  logic        inDa;

  assign inDa = (strobe.byteIdx <= DA_LAST_IDX);

  always_comb begin
    grpBase  = strobe.startFrame ? 1'b1 : grpOk;
    uniBase  = strobe.startFrame ? 1'b1 : uniOk;
    typeBase = strobe.startFrame ? 1'b1 : typeOk;
    opBase   = strobe.startFrame ? 1'b1 : opOk;
    grpNext  = grpBase;
    uniNext  = uniBase;
    typeNext = typeBase;
    opNext   = opBase;
    if (inDa) begin
      grpNext = grpBase && (rxByte == addrByte(GROUP_ADDR, strobe.byteIdx));
      uniNext = uniBase && (rxByte == addrByte(stationAddr, strobe.byteIdx));
    end
    case (strobe.byteIdx)
      TYPE_HI_IDX: typeNext = typeBase && (rxByte == PAUSE_TYPE[15:8]);
      TYPE_LO_IDX: typeNext = typeBase && (rxByte == PAUSE_TYPE[7:0]);
      OP_HI_IDX:   opNext   = opBase   && (rxByte == PAUSE_OP[15:8]);
      OP_LO_IDX:   opNext   = opBase   && (rxByte == PAUSE_OP[7:0]);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpOk     <= 1'b0;
      uniOk     <= 1'b0;
      typeOk    <= 1'b0;
      opOk      <= 1'b0;
      durShadow <= '0;
      quantaReg <= '0;
    end else begin
      if (strobe.takeByte) begin
        grpOk  <= grpNext;
        uniOk  <= uniNext;
        typeOk <= typeNext;
        opOk   <= opNext;
        if (strobe.byteIdx == DUR_HI_IDX) durShadow[15:8] <= rxByte;
        if (strobe.byteIdx == DUR_LO_IDX) durShadow[7:0]  <= rxByte;
      end
      if (strobe.commit) quantaReg <= durShadow;
    end
  end

  assign fieldsOk    = (grpOk || uniOk) && typeOk && opOk;
  assign pauseQuanta = quantaReg;

endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
  import pause_det_pkg::*;
#(
  parameter logic [47:0] GROUP_ADDR = 48'h0180_C200_0001,
  parameter logic [15:0] PAUSE_TYPE = 16'h8808,
  parameter logic [15:0] PAUSE_OP   = 16'h0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  rxByte,
  input  logic        byteValid,
  input  logic        sofIn,
  input  logic        eofIn,
  input  logic        eofGood,
  input  logic [47:0] stationAddr,
  input  logic        fullDuplex,
  input  logic        flowCtlEn,
  output logic        pauseHit,
  output logic [15:0] pauseQuanta
);

  ctlStrobe_t strobe;
  logic       fieldsOk;

  pause_det_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .sofIn      (sofIn),
    .eofIn      (eofIn),
    .eofGood    (eofGood),
    .fullDuplex (fullDuplex),
    .flowCtlEn  (flowCtlEn),
    .fieldsOk   (fieldsOk),
    .strobe     (strobe),
    .pauseHit   (pauseHit)
  );

  pause_det_dp #(
    .GROUP_ADDR (GROUP_ADDR),
    .PAUSE_TYPE (PAUSE_TYPE),
    .PAUSE_OP   (PAUSE_OP)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxByte      (rxByte),
    .stationAddr (stationAddr),
    .fieldsOk    (fieldsOk),
    .pauseQuanta (pauseQuanta)
  );

endmodule

// File: rtl/pause_det_chk.sv
module pause_det_chk (
  input logic        clk,
  input logic        rstN,
  input logic        eofIn,
  input logic        eofGood,
  input logic        fullDuplex,
  input logic        flowCtlEn,
  input logic        pauseHit,
  input logic [15:0] pauseQuanta
);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseHit |=> !pauseHit);

  // R6
  good_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseHit |-> $past(eofIn && eofGood));

  // R1
  enables_chk: assert property (@(posedge clk) disable iff (!rstN)
    pauseHit |-> $past(fullDuplex && flowCtlEn));

  // R5
  quanta_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pauseHit |-> $stable(pauseQuanta));

endmodule

bind pause_frame_detector pause_det_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .eofIn       (eofIn),
  .eofGood     (eofGood),
  .fullDuplex  (fullDuplex),
  .flowCtlEn   (flowCtlEn),
  .pauseHit    (pauseHit),
  .pauseQuanta (pauseQuanta)
);

// File: tb/tb_pause_frame_detector.sv
module tb_pause_frame_detector;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  rxByte;
  logic        byteValid, sofIn, eofIn, eofGood;
  logic [47:0] stationAddr;
  logic        fullDuplex, flowCtlEn;
  logic        pauseHit;
  logic [15:0] pauseQuanta;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  fr [0:63];
  logic [15:0] expQ = 16'h0000;
  bit          done = 1'b0;

  localparam logic [47:0] GROUP = 48'h0180_C200_0001;

  always #4 clk = ~clk;

  pause_frame_detector dut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .byteValid(byteValid),
    .sofIn(sofIn), .eofIn(eofIn), .eofGood(eofGood),
    .stationAddr(stationAddr), .fullDuplex(fullDuplex),
    .flowCtlEn(flowCtlEn), .pauseHit(pauseHit), .pauseQuanta(pauseQuanta)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [47:0] daOf();
    return {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]};
  endfunction

  function automatic bit expectPause(input int len, input bit good,
                                     input bit fd, input bit fce);
    logic [47:0] da;
    da = daOf();
    return fd && fce && good && (len >= 18)
           && (da == GROUP || da == stationAddr)
           && fr[12] == 8'h88 && fr[13] == 8'h08
           && fr[14] == 8'h00 && fr[15] == 8'h01;
  endfunction

  task automatic buildPause(input bit useStation, input logic [15:0] dur);
    logic [47:0] da;
    da = useStation ? stationAddr : GROUP;
    for (int i = 0; i < 6; i++) fr[i] = da[8*(5-i) +: 8];
    for (int i = 6; i < 12; i++) fr[i] = 8'($urandom);
    fr[12] = 8'h88; fr[13] = 8'h08; fr[14] = 8'h00; fr[15] = 8'h01;
    fr[16] = dur[15:8]; fr[17] = dur[7:0];
    for (int i = 18; i < 64; i++) fr[i] = 8'($urandom);
  endtask

  // prefix > 0: a partial frame of that many random bytes precedes a new sof
  task automatic sendFrame(input int len, input bit good, input bit fd,
                           input bit fce, input int prefix, input string req);
    bit exp;
    logic [15:0] oldQ;
    oldQ = expQ;
    exp = expectPause(len, good, fd, fce);
    fullDuplex = fd; flowCtlEn = fce;
    for (int i = 0; i < prefix; i++) begin
      @(negedge clk);
      byteValid = 1'b1; sofIn = (i == 0); rxByte = 8'($urandom);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byteValid = 1'b1; sofIn = (i == 0); rxByte = fr[i];
    end
    @(negedge clk);
    byteValid = 1'b0; sofIn = 1'b0;
    eofIn = 1'b1; eofGood = good;
    @(negedge clk);
    eofIn = 1'b0; eofGood = 1'b0;
    if (exp) expQ = {fr[16], fr[17]};
    check(pauseHit == exp, {req, " R9 verdict one cycle after eof"},
          32'(pauseHit), 32'(exp));
    check(pauseQuanta == expQ, {req, " R5 quanta"}, 32'(pauseQuanta), 32'(expQ));
    @(negedge clk);
    check(pauseHit == 1'b0, {req, " R9 pulse width"}, 32'(pauseHit), 0);
    check(pauseQuanta == expQ, {req, " R5 hold"}, 32'(pauseQuanta), 32'(expQ));
    if (!exp) begin
      check(pauseQuanta == oldQ, {req, " rejected frame leaves quanta"},
            32'(pauseQuanta), 32'(oldQ));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; rxByte = '0; byteValid = 0; sofIn = 0; eofIn = 0; eofGood = 0;
    stationAddr = 48'h02AB_CD12_3456; fullDuplex = 1; flowCtlEn = 1;
    repeat (3) @(negedge clk);
    check(pauseHit == 0, "R10 pauseHit at reset", 32'(pauseHit), 0);
    check(pauseQuanta == 0, "R10 quanta at reset", 32'(pauseQuanta), 0);
    rstN = 1'b1;

    // R2 group address
    buildPause(0, 16'h1234); sendFrame(18, 1, 1, 1, 0, "R2 group");
    // R2 station address, R5 max duration
    buildPause(1, 16'hFFFF); sendFrame(30, 1, 1, 1, 0, "R2 station");
    // R5 zero duration
    buildPause(0, 16'h0000); sendFrame(18, 1, 1, 1, 0, "R5 zero dur");
    // R2 other address
    buildPause(0, 16'h5555); fr[5] = 8'h02; sendFrame(18, 1, 1, 1, 0, "R2 wrong da");
    // R3 source all ones
    buildPause(0, 16'h0A0B); for (int i = 6; i < 12; i++) fr[i] = 8'hFF;
    sendFrame(18, 1, 1, 1, 0, "R3 source ignored");
    // R4 type / opcode
    buildPause(0, 16'h7777); fr[13] = 8'h09; sendFrame(18, 1, 1, 1, 0, "R4 bad type");
    buildPause(0, 16'h7777); fr[15] = 8'h02; sendFrame(18, 1, 1, 1, 0, "R4 bad opcode");
    // R6 bad status
    buildPause(0, 16'h4444); sendFrame(18, 0, 1, 1, 0, "R6 bad status");
    // R1 enables
    buildPause(1, 16'h4444); sendFrame(18, 1, 0, 1, 0, "R1 half duplex");
    buildPause(1, 16'h4444); sendFrame(18, 1, 1, 0, 0, "R1 fc disabled");
    // R7 short frame
    buildPause(0, 16'h3333); sendFrame(17, 1, 1, 1, 0, "R7 17 bytes");
    // R8 restart on sof mid-frame
    buildPause(0, 16'h2468); sendFrame(18, 1, 1, 1, 9, "R8 restart");
    // R8 bytes with no open frame are ignored
    buildPause(0, 16'h9999);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk); byteValid = 1'b1; sofIn = 1'b0; rxByte = fr[i];
    end
    @(negedge clk); byteValid = 0; eofIn = 1; eofGood = 1;
    @(negedge clk); eofIn = 0; eofGood = 0;
    check(pauseHit == 0, "R8 stray bytes", 32'(pauseHit), 0);
    check(pauseQuanta == expQ, "R8 stray quanta", 32'(pauseQuanta), 32'(expQ));

    // random mix
    for (int n = 0; n < 150; n++) begin
      int len, pick;
      bit good, fd, fce;
      buildPause(bit'($urandom % 2), 16'($urandom));
      len  = 14 + int'($urandom % 30);
      pick = int'($urandom % 10);
      if (pick == 1) fr[int'($urandom % 6)] ^= 8'h10;
      if (pick == 2) fr[12 + int'($urandom % 4)] ^= 8'h01;
      good = ($urandom % 8) != 0;
      fd   = ($urandom % 8) != 0;
      fce  = ($urandom % 8) != 0;
      sendFrame(len, good, fd, fce, (pick == 3) ? 5 : 0, "R1 R2 R4 R6 R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule